// File: doc/BRIEF.md
# Contact Card Power Sequencer

This block brings a contact smart card interface up and takes it down in a safe order. Activation begins when the interface is selected and a non-zero supply level is requested. The block then enables the card supply and waits for a supply-good indication. A watchdog limits that wait, and the block aborts into teardown if supply-good never arrives. Once the supply is good, it releases the I/O line, then starts the card clock, then lifts reset after a programmable delay. Finally it times the window in which the card must begin its answer to reset.

Teardown starts on a firmware command. It also starts by itself when the card is removed, an over-current is seen, or another error is reported while a session is under way. The contacts drop in a fixed order with two clock cycles between steps, and the supply is turned off last. Faults and timeouts are kept as sticky flags that firmware clears by writing ones. Any set flag raises the interrupt. All pins are plain control and status levels and carry no data stream, so no handshake applies. Every delay below is counted in cycles of `clk`, which also serves as the card clock reference.

Top module: `card_power_seq`

## Requirements
- R1: After reset, `vcc_en`, `io_rel`, `clk_en`, `rst_out`, `c4_out`, `c8_out`, `deact_done` and `irq` are 0, `flags_o` is 0 and `state_o` is 0 (idle).
- R2: Activation starts, with `vcc_en` rising and `state_o` becoming 1, only when all of the following hold: the block is idle, `if_sel`=1, `vsel`!=0, and `vsel` has read 0 for at least one cycle since the previous activation started. Reset counts as such a cycle.
- R3: If `vcc_ok` has not been sampled high by the edge that ends the `vcc_tmo` window, flag bit 0 (supply timeout) is set and teardown begins. In that case `io_rel` never rises, and `vcc_en` falls `vcc_tmo`+9 cycles after it rose. This holds in both modes.
- R4: With `ready_start`=0 and `vcc_ok` high at watchdog expiry, `io_rel` rises `vcc_tmo`+3 cycles after `vcc_en` rises.
- R5: With `ready_start`=1, `io_rel` rises 2 cycles after the edge that first samples `vcc_ok` high. That is 3 cycles after `vcc_en` if `vcc_ok` is already high. `c4_out` and `c8_out` rise together with `io_rel`.
- R6: `clk_en` rises 2 cycles after `io_rel`.
- R7: With `rst_hold`=0, `rst_out` (1 = reset released) rises `clk_rst_dly` cycles after `clk_en`. A value of 0 acts as 1.
- R8: While `rst_hold`=1, `rst_out` stays 0. `rst_out` rises on the `clk_rst_dly`-th edge that samples `rst_hold` low. Setting `rst_hold` during a session drives `rst_out` low on the next edge and sets `state_o` to 4.
- R9: After `rst_out` rises, flag bit 1 (answer timeout) is set `atr_limit` cycles later, unless a `ts_seen` pulse is sampled first. Either outcome moves `state_o` to 6 (session).
- R10: While active (`state_o` 1 to 6), any of the following starts teardown: `card_present`=0, `overcurrent`=1, `other_err`=1, or `deact_cmd`=1. The three faults set flag bits 2, 3 and 4 respectively. The command sets no flag. All four inputs are ignored when idle.
- R11: Counting from the edge that triggers teardown, `rst_out` is low after that edge, `clk_en` at +2, `io_rel` at +4, `c4_out`/`c8_out` at +6, and `vcc_en` at +8. At +8 `deact_done` is set and `state_o` returns to 0. `deact_done` clears when a new activation starts.
- R12: Flags are sticky and clear only where `flag_clr` holds a 1. A set in the same cycle wins over a clear. `irq` is the OR of all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the card clock reference |
| rst_n | input | 1 | Active-low reset |
| if_sel | input | 1 | Internal interface selected |
| vsel | input | VW | Supply level request, 0 = none |
| ready_start | input | 1 | 1: I/O release counts from supply-good alone |
| rst_hold | input | 1 | Firmware hold of card reset |
| deact_cmd | input | 1 | Firmware teardown request |
| vcc_ok | input | 1 | Supply good |
| card_present | input | 1 | Card inserted |
| overcurrent | input | 1 | Supply over-current |
| other_err | input | 1 | Other session error |
| ts_seen | input | 1 | Start byte of answer received (pulse) |
| vcc_tmo | input | TW | Supply watchdog window in cycles |
| clk_rst_dly | input | TW | CLK start to RST release delay |
| atr_limit | input | TW | Answer-to-reset timeout in cycles |
| flag_clr | input | 5 | Write-one-to-clear for flags |
| vcc_en | output | 1 | Card supply enable |
| io_rel | output | 1 | I/O line released high |
| clk_en | output | 1 | Card clock running |
| rst_out | output | 1 | Card RST level (0 = asserted) |
| c4_out | output | 1 | Auxiliary contact C4 |
| c8_out | output | 1 | Auxiliary contact C8 |
| deact_done | output | 1 | Teardown completed |
| irq | output | 1 | Any flag set |
| state_o | output | 4 | Sequencer state code |
| flags_o | output | 5 | Sticky flags: timeout supply, timeout answer, removal, over-current, other |

## Verification
Some properties are checked on every cycle by the assertions. The supply never comes up with another contact already driven, and it only rises under a qualified request. The clock never starts before I/O is released, and the auxiliary contacts rise together with I/O. Reset is never released while it is held or without a clock. All contacts are low at the moment the supply drops, and flags persist until written. Other behaviour can only be shown by the bench scenarios: the exact delays in both ready-start modes, watchdog aborts in both modes, answer-timeout versus start-byte races, the re-arm rule on the supply request, the spacing of each teardown step, and flag clearing one bit at a time.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_PWRUP    = 4'd1,
    ST_IO_WAIT  = 4'd2,
    ST_CLK_WAIT = 4'd3,
    ST_RST_WAIT = 4'd4,
    ST_ATR_WAIT = 4'd5,
    ST_SESSION  = 4'd6,
    ST_DN_RST   = 4'd7,
    ST_DN_CLK   = 4'd8,
    ST_DN_IO    = 4'd9,
    ST_DN_AUX   = 4'd10
  } seq_state_e;

  localparam int FLAG_N = 5;
  localparam int FL_SUP = 0;
  localparam int FL_ATR = 1;
  localparam int FL_RM  = 2;
  localparam int FL_OC  = 3;
  localparam int FL_ERR = 4;
endpackage

// File: rtl/seq_countdown.sv
module seq_countdown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R7: delays elapse one count per cycle once loaded
  a_r7_step_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/seq_flags.sv
module seq_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end

  assign irq = |flags;

  // R12: a flag not written with one stays set
  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));
endmodule

// File: rtl/card_power_seq.sv
module card_power_seq
  import card_seq_pkg::*;
#(
  parameter int TW       = 16,
  parameter int VW       = 2,
  parameter int IO_GAP   = 2,
  parameter int CLK_GAP  = 2,
  parameter int STEP_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_sel,
  input  logic [VW-1:0]     vsel,
  input  logic              ready_start,
  input  logic              rst_hold,
  input  logic              deact_cmd,
  input  logic              vcc_ok,
  input  logic              card_present,
  input  logic              overcurrent,
  input  logic              other_err,
  input  logic              ts_seen,
  input  logic [TW-1:0]     vcc_tmo,
  input  logic [TW-1:0]     clk_rst_dly,
  input  logic [TW-1:0]     atr_limit,
  input  logic [FLAG_N-1:0] flag_clr,
  output logic              vcc_en,
  output logic              io_rel,
  output logic              clk_en,
  output logic              rst_out,
  output logic              c4_out,
  output logic              c8_out,
  output logic              deact_done,
  output logic              irq,
  output logic [3:0]        state_o,
  output logic [FLAG_N-1:0] flags_o
);
  localparam logic [TW-1:0] IO_LD   = TW'(IO_GAP - 1);
  localparam logic [TW-1:0] CLK_LD  = TW'(CLK_GAP - 1);
  localparam logic [TW-1:0] STEP_LD = TW'(STEP_GAP - 1);

  seq_state_e        state, nxt;
  logic              armed, start, active, trip;
  logic              tmr_load, tmr_zero, wd_load, wd_zero;
  logic [TW-1:0]     tmr_val, rst_ld, atr_ld;
  logic [FLAG_N-1:0] fset;
  logic              aux_on;

  assign rst_ld = (clk_rst_dly == '0) ? '0 : clk_rst_dly - 1'b1;
  assign atr_ld = (atr_limit == '0) ? '0 : atr_limit - 1'b1;
  assign start  = (state == ST_IDLE) && if_sel && (vsel != '0) && armed;
  assign active = state inside {ST_PWRUP, ST_IO_WAIT, ST_CLK_WAIT,
                                ST_RST_WAIT, ST_ATR_WAIT, ST_SESSION};
  assign trip   = active && (!card_present || overcurrent || other_err || deact_cmd);

  // request must pass through zero before it can start again
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            armed <= 1'b1;
    else if (vsel == '0)   armed <= 1'b1;
    else if (start)        armed <= 1'b0;
  end

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    wd_load  = 1'b0;
    fset     = '0;
    if (trip) begin
      nxt          = ST_DN_RST;
      tmr_load     = 1'b1;
      tmr_val      = STEP_LD;
      fset[FL_RM]  = !card_present;
      fset[FL_OC]  = overcurrent;
      fset[FL_ERR] = other_err;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          nxt     = ST_PWRUP;
          wd_load = 1'b1;
        end
        ST_PWRUP: begin
          if (vcc_ok && (ready_start || wd_zero)) begin
            nxt      = ST_IO_WAIT;
            tmr_load = 1'b1;
            tmr_val  = IO_LD;
          end else if (wd_zero) begin
            nxt          = ST_DN_RST;
            tmr_load     = 1'b1;
            tmr_val      = STEP_LD;
            fset[FL_SUP] = 1'b1;
          end
        end
        ST_IO_WAIT: if (tmr_zero) begin
          nxt      = ST_CLK_WAIT;
          tmr_load = 1'b1;
          tmr_val  = CLK_LD;
        end
        ST_CLK_WAIT: if (tmr_zero) begin
          nxt      = ST_RST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = rst_ld;
        end
        ST_RST_WAIT: begin
          if (rst_hold) begin
            tmr_load = 1'b1;
            tmr_val  = rst_ld;
          end else if (tmr_zero) begin
            nxt      = ST_ATR_WAIT;
            tmr_load = 1'b1;
            tmr_val  = atr_ld;
          end
        end
        ST_ATR_WAIT: begin
          if (ts_seen) nxt = ST_SESSION;
          else if (tmr_zero) begin
            nxt          = ST_SESSION;
            fset[FL_ATR] = 1'b1;
          end
        end
        ST_SESSION: if (rst_hold) begin
          nxt      = ST_RST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = rst_ld;
        end
        ST_DN_RST, ST_DN_CLK, ST_DN_IO: if (tmr_zero) begin
          nxt      = seq_state_e'(state + 4'd1);
          tmr_load = 1'b1;
          tmr_val  = STEP_LD;
        end
        ST_DN_AUX: if (tmr_zero) nxt = ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  // contact levels change only on entry into a state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      vcc_en     <= 1'b0;
      io_rel     <= 1'b0;
      clk_en     <= 1'b0;
      rst_out    <= 1'b0;
      aux_on     <= 1'b0;
      deact_done <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state) begin
        unique case (nxt)
          ST_PWRUP:    begin vcc_en <= 1'b1; deact_done <= 1'b0; end
          ST_CLK_WAIT: begin io_rel <= 1'b1; aux_on <= 1'b1; end
          ST_RST_WAIT: begin clk_en <= 1'b1; rst_out <= 1'b0; end
          ST_ATR_WAIT: rst_out <= 1'b1;
          ST_DN_RST:   rst_out <= 1'b0;
          ST_DN_CLK:   clk_en <= 1'b0;
          ST_DN_IO:    io_rel <= 1'b0;
          ST_DN_AUX:   aux_on <= 1'b0;
          ST_IDLE:     begin vcc_en <= 1'b0; deact_done <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  assign c4_out  = aux_on;
  assign c8_out  = aux_on;
  assign state_o = state;

  seq_countdown #(.W(TW)) u_step_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

  seq_countdown #(.W(TW)) u_wd_tmr (
    .clk(clk), .rst_n(rst_n), .load(wd_load), .load_val(vcc_tmo), .zero(wd_zero));

  seq_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(fset), .clr(flag_clr), .flags(flags_o), .irq(irq));

  // R2: supply only rises under a qualified request
  a_r2_start_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_en) |-> ($past(if_sel) && ($past(vsel) != '0)));
  // R5: supply comes first, auxiliary contacts follow I/O
  a_r5_vcc_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_en) |-> !(io_rel || clk_en || rst_out));
  a_r5_aux_with_io: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_rel) |-> (c4_out && c8_out));
  // R6: clock never starts ahead of I/O release
  a_r6_clk_after_io: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> io_rel);
  // R8: reset released only with clock and no hold
  a_r8_rst_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> (clk_en && !$past(rst_hold)));
  // R11: every contact low when the supply drops
  a_r11_contacts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> (!(rst_out || clk_en || io_rel || c4_out || c8_out) && deact_done));
endmodule

// File: tb/card_power_seq_tb.sv
`timescale 1ns/1ps
module card_power_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_sel = 0, ready_start = 0, rst_hold = 0, deact_cmd = 0, vcc_ok = 0;
  logic card_present = 1, overcurrent = 0, other_err = 0, ts_seen = 0;
  logic [1:0]  vsel = '0;
  logic [15:0] vcc_tmo = '0, clk_rst_dly = '0, atr_limit = '0;
  logic [4:0]  flag_clr = '0;
  logic vcc_en, io_rel, clk_en, rst_out, c4_out, c8_out, deact_done, irq;
  logic [3:0] state_o;
  logic [4:0] flags_o;

  int nchk = 0, nfail = 0, cyc = 0;
  int t_vcc, t_voff, t_io, t_clk, t_rst;
  logic pv = 0, pi = 0, pc = 0, pr = 0;

  always #2.5 clk = ~clk;

  card_power_seq u_dut (
    .clk(clk), .rst_n(rst_n), .if_sel(if_sel), .vsel(vsel), .ready_start(ready_start),
    .rst_hold(rst_hold), .deact_cmd(deact_cmd), .vcc_ok(vcc_ok), .card_present(card_present),
    .overcurrent(overcurrent), .other_err(other_err), .ts_seen(ts_seen), .vcc_tmo(vcc_tmo),
    .clk_rst_dly(clk_rst_dly), .atr_limit(atr_limit), .flag_clr(flag_clr),
    .vcc_en(vcc_en), .io_rel(io_rel), .clk_en(clk_en), .rst_out(rst_out), .c4_out(c4_out),
    .c8_out(c8_out), .deact_done(deact_done), .irq(irq), .state_o(state_o), .flags_o(flags_o));

  always @(posedge clk) cyc <= cyc + 1;

  // edge-time recorder, sampled just after each rising edge
  always @(posedge clk) begin
    #1;
    if (vcc_en && !pv) t_vcc = cyc;
    if (!vcc_en && pv) t_voff = cyc;
    if (io_rel && !pi) t_io = cyc;
    if (clk_en && !pc) t_clk = cyc;
    if (rst_out && !pr) t_rst = cyc;
    pv = vcc_en; pi = io_rel; pc = clk_en; pr = rst_out;
  end

  // ready_start, vcc_tmo, ok_delay, clk_rst_dly, atr_limit, send_ts,
  // exp io gap, exp supply timeout, exp vcc fall gap, exp atr flag
  localparam int NV = 7;
  localparam int VEC [0:NV-1][0:9] = '{
    '{0,  5,  0, 3, 10, 1,  8, 0,  0, 0},
    '{1, 20,  0, 1,  6, 0,  3, 0,  0, 1},
    '{1, 20,  4, 5,  4, 1,  7, 0,  0, 0},
    '{0,  6,  3, 2,  3, 0,  9, 0,  0, 1},
    '{0,  4, 99, 2,  3, 0,  0, 1, 13, 0},
    '{1,  3, 99, 2,  3, 0,  0, 1, 12, 0},
    '{0,  2,  5, 2,  3, 0,  0, 1, 11, 0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_flags();
    flag_clr = '1; step(1); flag_clr = '0;
    chk("R12 clear all", int'(irq), 0);
  endtask

  task automatic run_vec(input int i);
    bit ach;
    vsel = '0; vcc_ok = 0; step(2);
    ready_start = VEC[i][0][0];
    vcc_tmo = 16'(VEC[i][1]); clk_rst_dly = 16'(VEC[i][3]); atr_limit = 16'(VEC[i][4]);
    t_vcc = -1; t_voff = -1; t_io = -1; t_clk = -1; t_rst = -1; ach = 0;
    vsel = 2'b11;
    for (int n = 0; n < 400; n++) begin
      step(1);
      if (t_vcc >= 0 && cyc - t_vcc == VEC[i][2]) vcc_ok = 1;
      ts_seen = (VEC[i][5] == 1 && t_rst >= 0 && cyc - t_rst == 1);
      if (t_rst >= 0 && cyc - t_rst == VEC[i][4]) begin
        chk("R9 answer timeout flag", int'(flags_o[1]), VEC[i][9]);
        ach = 1;
      end
      if (VEC[i][7] == 1 ? (t_voff >= 0) : ach) break;
    end
    ts_seen = 0;
    if (VEC[i][7] == 1) begin
      chk("R3 supply timeout flag", int'(flags_o[0]), 1);
      chk("R3 vcc fall gap", t_voff - t_vcc, VEC[i][8]);
      chk("R3 io never released", t_io, -1);
    end else begin
      chk(VEC[i][0] == 0 ? "R4 io gap" : "R5 io gap", t_io - t_vcc, VEC[i][6]);
      chk("R6 clk gap", t_clk - t_io, 2);
      chk("R7 rst gap", t_rst - t_clk, VEC[i][3]);
      deact_cmd = 1; step(1); deact_cmd = 0; step(10);
      chk("R11 off and done", int'({vcc_en, deact_done}), 1);
      chk("R10 command sets no fault flag", int'(flags_o[4:2]), 0);
    end
    clear_flags();
  endtask

  initial begin : wd
    #(5ns * 150000);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n;
    step(3); rst_n = 1; step(1);
    // R1 reset state
    chk("R1 outputs", int'({vcc_en, io_rel, clk_en, rst_out, c4_out, c8_out, deact_done, irq}), 0);
    chk("R1 state and flags", int'({state_o, flags_o}), 0);
    // R2 no start without interface select
    vsel = 2'b01; step(6);
    chk("R2 if_sel low", int'(vcc_en), 0);
    if_sel = 1;
    step(2);
    for (int i = 0; i < NV; i++) run_vec(i);

    // R2 request must pass through zero
    step(8);
    chk("R2 no restart without rearm", int'({vcc_en, state_o}), 0);
    ready_start = 1; vcc_ok = 1; rst_hold = 1; clk_rst_dly = 16'd3; atr_limit = 16'd50;
    vsel = '0; step(1); vsel = 2'b11; step(1);
    chk("R2 restart after rearm", int'(vcc_en), 1);
    step(20);
    chk("R8 held reset", int'({clk_en, rst_out}), 2);
    rst_hold = 0; n = 0;
    do begin step(1); n++; end while (!rst_out && n < 50);
    chk("R8 release delay", n, 3);
    ts_seen = 1; step(1); ts_seen = 0;
    chk("R9 start byte enters session", int'(state_o), 6);
    step(60);
    chk("R9 start byte cancels timeout", int'(flags_o[1]), 0);
    rst_hold = 1; step(1);
    chk("R8 hold in session", int'({rst_out, state_o}), 4);
    rst_hold = 0; step(5);
    ts_seen = 1; step(1); ts_seen = 0;

    // R11 teardown order after card removal
    card_present = 0;
    for (int k = 1; k <= 9; k++) begin
      step(1);
      chk("R11 teardown step",
          int'({vcc_en, io_rel, clk_en, rst_out, c4_out, c8_out}),
          int'({k < 9, k < 5, k < 3, 1'b0, k < 7, k < 7}));
    end
    chk("R11 done idle", int'({deact_done, state_o}), 16);
    chk("R10 removal flag", int'({irq, flags_o}), 6'b100100);
    card_present = 1;

    // R10 over-current while powering up
    vsel = '0; vcc_ok = 0; step(1); vsel = 2'b11; step(2);
    overcurrent = 1; step(1); overcurrent = 0; step(9);
    chk("R10 over-current teardown", int'(vcc_en), 0);
    chk("R10 over-current flag", int'(flags_o), 5'b01100);
    // R12 selective clear
    flag_clr = 5'b01000; step(1); flag_clr = '0;
    chk("R12 partial clear", int'(flags_o), 5'b00100);
    chk("R12 irq stays", int'(irq), 1);
    clear_flags();

    // R10 idle ignores command and faults
    other_err = 1; deact_cmd = 1; step(3); other_err = 0; deact_cmd = 0; step(1);
    chk("R10 idle ignore", int'({state_o, flags_o, deact_done}), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule